// File: doc/BRIEF.md
# Operand-2 Shift and Rotate Unit

This block is a purely combinational 32-bit shifter that sits in front of the ALU. It prepares the second operand of a data-processing operation. It takes a value, a 2-bit shift kind and the current carry flag. It also takes a shift amount from one of two sources: a 5-bit immediate field, or the low byte of a register. It returns the shifted value and the shifter carry-out. The execute stage uses that carry-out as the new carry flag for logical operations.

Four kinds are supported: logical left, logical right, arithmetic right and rotate right. Amounts of 32 and above, which can only arrive from the register source, follow fixed saturation rules. An amount of zero leaves both the value and the carry untouched. Writeback and flag storage stay in the execute unit.

Top module: `op2_shifter`

## Requirements
- R1: The shift kind is encoded 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. Logical left by n (1..31) moves every bit up n places and zero-fills the low end. For example, 0x00000500 by 8 gives 0x00050000.
- R2: Logical right by n (1..31) zero-fills the high end. For example, 0x00000500 by 4 gives 0x00000050.
- R3: Arithmetic right by n (1..31) copies bit 31 of the input into the n vacated high bits.
- R4: Rotate right by n (1..31) re-enters the bits leaving bit 0 at bit 31. For example, 0x0000FFFF by 16 gives 0xFFFF0000.
- R5: When `amt_src_reg_i` is 1, the amount is the 8-bit `amt_reg_i` and `amt_imm_i` has no effect. When it is 0, the amount is the 5-bit `amt_imm_i` and `amt_reg_i` has no effect.
- R6: An amount of zero passes the value through unchanged, and `carry_o` equals `carry_i`.
- R7: For amounts 1..31, `carry_o` is the last bit shifted out. That is input bit 32-n for logical left, and input bit n-1 for both right shifts.
- R8: Logical left by exactly 32 gives 0 with carry equal to input bit 0. Logical right by exactly 32 gives 0 with carry equal to input bit 31.
- R9: Either logical shift by more than 32 gives 0 with carry 0.
- R10: Arithmetic right by 32 or more sets every result bit, and the carry, to input bit 31.
- R11: Rotate right uses the amount modulo 32, and `carry_o` equals result bit 31 for any non-zero amount. A non-zero multiple of 32 returns the input unchanged with carry equal to input bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Value to be shifted |
| kind_i | input | 2 | Shift kind (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| amt_src_reg_i | input | 1 | 1 selects the register amount, 0 the immediate |
| amt_imm_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| shifted_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shifter carry-out |

## Verification
No register lies between any input and either output, so both results are due in the same cycle as the stimulus, after combinational settling only. The bench changes inputs just after a rising edge of its own pacing clock and compares both outputs at the next falling edge, half a period later. Each directed scenario drives one operand pattern and reads `shifted_o` and `carry_o` together in that window before it moves on.

// File: rtl/op2_shift_pkg.sv
package op2_shift_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  function automatic logic [DATA_W-1:0] bit_reverse(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/op2_amt_sel.sv
module op2_amt_sel #(
  parameter int unsigned IMM_W = 5,
  parameter int unsigned REG_W = 8
) (
  input  logic             src_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [REG_W-1:0] reg_i,
  output logic [REG_W-1:0] amt_o
);

  localparam int unsigned PAD_W = REG_W - IMM_W;

  assign amt_o = src_reg_i ? reg_i : {{PAD_W{1'b0}}, imm_i};

endmodule

// File: rtl/op2_barrel.sv
// Log-depth right shifter; a spill bit below bit 0 catches the last bit out.
module op2_barrel #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic          rotate_i,
  input  logic          fill_i,
  output logic [W-1:0]  data_o,
  output logic          spill_o
);

  logic [W:0] stg [0:AW];

  assign stg[0] = {data_i, 1'b0};

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [W-1:0] cur;
    logic [W-1:0] rot;
    logic [W:0]   shf;
    assign cur = stg[k][W:1];
    assign rot = {cur[S-1:0], cur[W-1:S]};
    assign shf = {{S{fill_i}}, stg[k][W:S]};
    assign stg[k+1] = !amt_i[k] ? stg[k] : (rotate_i ? {rot, 1'b0} : shf);
  end

  assign data_o  = stg[AW][W:1];
  assign spill_o = stg[AW][0];

  always_comb begin
    if (rotate_i)
      a_r4_rotate_keeps_ones: assert ($countones(data_o) == $countones(data_i));
    if (!rotate_i && amt_i != '0)
      a_r3_fill_top: assert (data_o[W-1] == fill_i);
  end

endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import op2_shift_pkg::*;
#(
  parameter int unsigned IMM_W = 5,
  parameter int unsigned REG_W = 8
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        kind_i,
  input  logic              amt_src_reg_i,
  input  logic [IMM_W-1:0]  amt_imm_i,
  input  logic [REG_W-1:0]  amt_reg_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] shifted_o,
  output logic              carry_o
);

  localparam int unsigned AW = $clog2(DATA_W);
  localparam logic [REG_W-1:0] AMT_FULL = REG_W'(DATA_W);

  shift_kind_e       kind;
  logic [REG_W-1:0]  amt;
  logic [DATA_W-1:0] core_in, core_out;
  logic              core_spill;
  logic              amt_zero, amt_full, amt_over, low_zero;
  logic              sign;

  assign kind = shift_kind_e'(kind_i);
  assign sign = opnd_i[DATA_W-1];

  op2_amt_sel #(.IMM_W(IMM_W), .REG_W(REG_W)) u_amt (
    .src_reg_i (amt_src_reg_i),
    .imm_i     (amt_imm_i),
    .reg_i     (amt_reg_i),
    .amt_o     (amt)
  );

  assign amt_zero = (amt == '0);
  assign amt_full = (amt == AMT_FULL);
  assign amt_over = (amt > AMT_FULL);
  assign low_zero = (amt[AW-1:0] == '0);

  // left shifts run through the right shifter on a mirrored word
  assign core_in = (kind == SK_LSL) ? bit_reverse(opnd_i) : opnd_i;

  op2_barrel #(.W(DATA_W), .AW(AW)) u_core (
    .data_i   (core_in),
    .amt_i    (amt[AW-1:0]),
    .rotate_i (kind == SK_ROR),
    .fill_i   ((kind == SK_ASR) && sign),
    .data_o   (core_out),
    .spill_o  (core_spill)
  );

  always_comb begin
    shifted_o = core_out;
    carry_o   = core_spill;
    if (amt_zero) begin
      shifted_o = opnd_i;
      carry_o   = carry_i;
    end else begin
      unique case (kind)
        SK_LSL: begin
          if (amt_full) begin
            shifted_o = '0;
            carry_o   = opnd_i[0];
          end else if (amt_over) begin
            shifted_o = '0;
            carry_o   = 1'b0;
          end else begin
            shifted_o = bit_reverse(core_out);
          end
        end
        SK_LSR: begin
          if (amt_full) begin
            shifted_o = '0;
            carry_o   = sign;
          end else if (amt_over) begin
            shifted_o = '0;
            carry_o   = 1'b0;
          end
        end
        SK_ASR: begin
          if (amt_full || amt_over) begin
            shifted_o = {DATA_W{sign}};
            carry_o   = sign;
          end
        end
        SK_ROR: begin
          if (low_zero) shifted_o = opnd_i;
          carry_o = shifted_o[DATA_W-1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (kind == SK_ASR)
      a_r10_sign_kept: assert (shifted_o[DATA_W-1] == sign);
    if (kind == SK_ROR && !amt_zero)
      a_r11_ror_carry_top: assert (carry_o == shifted_o[DATA_W-1]);
    if (kind == SK_LSL && !amt_zero)
      a_r1_lsl_low_zero: assert (shifted_o[0] == 1'b0);
    if ((kind == SK_LSL || kind == SK_LSR) && amt_over)
      a_r9_logical_over: assert (shifted_o == '0 && !carry_o);
    if (kind == SK_ROR)
      a_r4_ror_weight: assert ($countones(shifted_o) == $countones(opnd_i));
  end

endmodule

// File: tb/op2_shifter_tb.sv
module op2_shifter_tb;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [1:0]  kind;
  logic        src_reg;
  logic [4:0]  amt_imm;
  logic [7:0]  amt_reg;
  logic        cin;
  logic [31:0] shifted;
  logic        cout;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  op2_shifter u_dut (
    .opnd_i        (opnd),
    .kind_i        (kind),
    .amt_src_reg_i (src_reg),
    .amt_imm_i     (amt_imm),
    .amt_reg_i     (amt_reg),
    .carry_i       (cin),
    .shifted_o     (shifted),
    .carry_o       (cout)
  );

  task automatic drive(input logic [1:0] k, input logic sr, input logic [4:0] im,
                       input logic [7:0] rg, input logic c, input logic [31:0] v);
    @(posedge clk);
    #1;
    kind = k; src_reg = sr; amt_imm = im; amt_reg = rg; cin = c; opnd = v;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp_v, input logic exp_c);
    n_run++;
    if (shifted !== exp_v || cout !== exp_c) begin
      n_fail++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, shifted, cout, exp_v, exp_c);
    end
  endtask

  task automatic t_idle();
    drive(2'b00, 1'b0, 5'd0, 8'd0, 1'b0, 32'h0);
    check("R6 idle", 32'h0, 1'b0);
  endtask

  task automatic t_lsl();
    drive(2'b00, 1'b0, 5'd8, 8'd0, 1'b0, 32'h0000_0500);
    check("R1", 32'h0005_0000, 1'b0);
    drive(2'b00, 1'b0, 5'd4, 8'd0, 1'b0, 32'hF000_0001);
    check("R1 R7", 32'h0000_0010, 1'b1);
    drive(2'b00, 1'b0, 5'd31, 8'd0, 1'b1, 32'h0000_0001);
    check("R1 R7 n=31", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_lsr();
    drive(2'b01, 1'b0, 5'd4, 8'd0, 1'b1, 32'h0000_0500);
    check("R2", 32'h0000_0050, 1'b0);
    drive(2'b01, 1'b0, 5'd1, 8'd0, 1'b0, 32'h0000_0003);
    check("R2 R7", 32'h0000_0001, 1'b1);
    drive(2'b01, 1'b0, 5'd31, 8'd0, 1'b1, 32'h8000_0000);
    check("R2 R7 n=31", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_asr();
    drive(2'b10, 1'b0, 5'd4, 8'd0, 1'b1, 32'h8000_0010);
    check("R3", 32'hF800_0001, 1'b0);
    drive(2'b10, 1'b0, 5'd1, 8'd0, 1'b0, 32'h8000_0001);
    check("R3 R7", 32'hC000_0000, 1'b1);
    drive(2'b10, 1'b0, 5'd4, 8'd0, 1'b0, 32'h7000_0000);
    check("R3 positive", 32'h0700_0000, 1'b0);
  endtask

  task automatic t_ror();
    drive(2'b11, 1'b0, 5'd16, 8'd0, 1'b0, 32'h0000_FFFF);
    check("R4", 32'hFFFF_0000, 1'b1);
    drive(2'b11, 1'b0, 5'd4, 8'd0, 1'b1, 32'h0000_0012);
    check("R4 R11", 32'h2000_0001, 1'b0);
  endtask

  task automatic t_zero();
    drive(2'b00, 1'b0, 5'd0, 8'd0, 1'b1, 32'hDEAD_BEEF);
    check("R6 c=1", 32'hDEAD_BEEF, 1'b1);
    drive(2'b10, 1'b0, 5'd0, 8'd0, 1'b0, 32'hDEAD_BEEF);
    check("R6 c=0", 32'hDEAD_BEEF, 1'b0);
    drive(2'b11, 1'b1, 5'd9, 8'd0, 1'b1, 32'h1234_5678);
    check("R6 reg zero", 32'h1234_5678, 1'b1);
  endtask

  task automatic t_source();
    drive(2'b00, 1'b1, 5'd3, 8'd8, 1'b0, 32'h0000_0500);
    check("R5 reg", 32'h0005_0000, 1'b0);
    drive(2'b00, 1'b0, 5'd3, 8'd8, 1'b0, 32'h0000_0500);
    check("R5 imm", 32'h0000_2800, 1'b0);
  endtask

  task automatic t_full();
    drive(2'b00, 1'b1, 5'd0, 8'd32, 1'b0, 32'h0000_0001);
    check("R8 lsl32", 32'h0, 1'b1);
    drive(2'b01, 1'b1, 5'd0, 8'd32, 1'b0, 32'h8000_0000);
    check("R8 lsr32", 32'h0, 1'b1);
    drive(2'b01, 1'b1, 5'd0, 8'd32, 1'b1, 32'h7FFF_FFFF);
    check("R8 lsr32 c0", 32'h0, 1'b0);
  endtask

  task automatic t_over();
    drive(2'b00, 1'b1, 5'd0, 8'd33, 1'b1, 32'hFFFF_FFFF);
    check("R9 lsl33", 32'h0, 1'b0);
    drive(2'b01, 1'b1, 5'd0, 8'd255, 1'b1, 32'hFFFF_FFFF);
    check("R9 lsr255", 32'h0, 1'b0);
  endtask

  task automatic t_asr_big();
    drive(2'b10, 1'b1, 5'd0, 8'd32, 1'b0, 32'h8000_0000);
    check("R10 asr32", 32'hFFFF_FFFF, 1'b1);
    drive(2'b10, 1'b1, 5'd0, 8'd200, 1'b1, 32'h7FFF_FFFF);
    check("R10 asr200", 32'h0, 1'b0);
  endtask

  task automatic t_ror_mod();
    drive(2'b11, 1'b1, 5'd0, 8'd36, 1'b1, 32'h0000_0012);
    check("R11 ror36", 32'h2000_0001, 1'b0);
    drive(2'b11, 1'b1, 5'd0, 8'd32, 1'b0, 32'h8000_0001);
    check("R11 ror32", 32'h8000_0001, 1'b1);
    drive(2'b11, 1'b1, 5'd0, 8'd33, 1'b0, 32'h0000_0001);
    check("R11 ror33", 32'h8000_0000, 1'b1);
  endtask

  initial begin
    #(CLK_P * 5000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_idle();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_zero();
    t_source();
    t_full();
    t_over();
    t_asr_big();
    t_ror_mod();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule